// File: doc/BRIEF.md
# Windowed Watchdog and Periodic Tick Timer

This peripheral sits on an APB bus with a 16-bit data path and offers two services driven by one slow time base. A single-cycle enable pulse from a slow clock domain, already synchronised into the bus clock, feeds a 5-bit prescaler. The prescaler emits one tick every DIV+1 slow pulses. The tick drives a 16-bit periodic down-counter that flags an interrupt on reaching zero, and an 8-bit watchdog counter.

Software must service the watchdog by writing the programmed match byte while the counter has fallen to or below a window threshold. A service that is too early, too late or carries the wrong byte sets its own sticky status bit and pulses the error output. Either register section can be locked until reset. A freeze input stops all counting while it is high, which supports debug halts.

The bus has no wait states. A write takes effect on the clock edge of its access phase, and read data is combinational from the address.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, every readable address (0 to 9) returns 0 and both `tmr_irq_o` and `wd_err_o` are low.
- R2: The prescaler counts slow pulses, taking DIV from address 0 bits [4:0]. On the slow pulse where its count equals DIV it emits a tick and returns to 0, so a tick arrives every DIV+1 pulses.
- R3: Address 2 holds the timer control: bit0 run, bit1 auto-reload, bit2 interrupt enable. Writing it with bit0=1 loads the timer count (read at address 8) from the start value at address 1. Each tick while running decrements the count. The tick that takes the count from 1 to 0 sets the terminal flag (status bit0). `tmr_irq_o` equals the flag AND the interrupt enable.
- R4: At that zero crossing the count reloads the start value when auto-reload is set. Otherwise it holds 0 until the timer is started again.
- R5: Writing 1 to status bit0 (address 6) clears the terminal flag. A flag set in the same cycle wins.
- R6: Address 3 holds the reload value in bits [7:0] and the window threshold in bits [15:8]. Address 4 holds the enable in bit0 and the match byte in bits [15:8]; writing it with bit0=1 loads the watchdog count (read at address 9) from the reload value. A tick that takes the enabled count from 1 to 0 is a late fault: it sets status bit2 and reloads the count.
- R7: A service is a write to address 5 with the byte in bits [7:0], and it counts only while the watchdog is enabled. A service with the correct byte while the count is above the window is an early fault: it sets status bit1 and leaves the count unchanged.
- R8: A service whose byte differs from the match byte is a mismatch fault. It sets status bit3, takes precedence over the early check and does not reload.
- R9: A service with the correct byte while the count is at or below the window reloads the count and suppresses a tick in the same cycle.
- R10: `wd_err_o` goes high for one clock in the cycle after each cycle that holds any fault. Status bits 1 to 3 stay set until reset.
- R11: Writing address 7 sets lock bits: bit0 locks addresses 0 to 2, bit1 locks addresses 3 and 4. Writing 0 clears no lock bit. Writes to a locked address are ignored, and only reset clears the locks.
- R12: While `freeze_i` is high the prescaler, timer and watchdog counts do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_en_i | input | 1 | One-cycle pulse per slow clock period |
| freeze_i | input | 1 | Debug halt of all counting |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | 4 | Register index |
| pwdata_i | input | 16 | Write data |
| prdata_o | output | 16 | Read data |
| tmr_irq_o | output | 1 | Timer interrupt (level) |
| wd_err_o | output | 1 | Watchdog fault pulse |

## Verification
A prescaler count that has slipped moves every later tick, so `tmr_irq_o` rises on the wrong clock within one timer period. A corrupted watchdog count turns a valid service into an early fault, or a late fault appears, and either one shows on `wd_err_o` one clock after the event. Wrong lock or freeze state shows on the next read of a configuration or count register. The per-cycle comparison against a bench model therefore reports most internal faults within a few dozen clocks.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_PRE   = 4'd0;
  localparam logic [ADDR_W-1:0] A_TLOAD = 4'd1;
  localparam logic [ADDR_W-1:0] A_TCTRL = 4'd2;
  localparam logic [ADDR_W-1:0] A_WCFG  = 4'd3;
  localparam logic [ADDR_W-1:0] A_WCTRL = 4'd4;
  localparam logic [ADDR_W-1:0] A_SVC   = 4'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd6;
  localparam logic [ADDR_W-1:0] A_LOCK  = 4'd7;
  localparam logic [ADDR_W-1:0] A_TCNT  = 4'd8;
  localparam logic [ADDR_W-1:0] A_WCNT  = 4'd9;

  localparam int unsigned TC_RUN  = 0;
  localparam int unsigned TC_AUTO = 1;
  localparam int unsigned TC_IE   = 2;

  // sticky fault vector order
  localparam int unsigned F_EARLY = 0;
  localparam int unsigned F_LATE  = 1;
  localparam int unsigned F_MIS   = 2;
  localparam int unsigned NFAULT  = 3;
endpackage

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int unsigned PRE_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_en_i,
  input  logic             freeze_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             step;

  assign step   = slow_en_i & ~freeze_i;
  assign tick_o = step & (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  a_r12_prescale_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(cnt_q));
  a_r2_tick_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             auto_i,
  input  logic [TMR_W-1:0] load_i,
  input  logic             start_i,
  input  logic             clr_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             flag_o
);
  logic [TMR_W-1:0] cnt_q;
  logic             flag_q;
  logic             adv, hit;

  assign adv = tick_i & run_i & ~start_i & (cnt_q != '0);
  assign hit = adv & (cnt_q == TMR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (start_i)  cnt_q <= load_i;
      else if (hit) cnt_q <= auto_i ? load_i : '0;
      else if (adv) cnt_q <= cnt_q - 1'b1;
      if (hit)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  a_r3_flag_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q);
  a_r4_zero_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !start_i) |=> (cnt_q == '0));
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog
  import tw_pkg::*;
#(
  parameter int unsigned WD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [WD_W-1:0]   reload_i,
  input  logic [WD_W-1:0]   window_i,
  input  logic [WD_W-1:0]   match_i,
  input  logic              svc_i,
  input  logic [WD_W-1:0]   svc_data_i,
  output logic [WD_W-1:0]   cnt_o,
  output logic [NFAULT-1:0] sticky_o,
  output logic              err_o
);
  logic [WD_W-1:0]   cnt_q;
  logic [NFAULT-1:0] sticky_q, fault;
  logic              err_q, svc, good, adv;

  assign svc            = svc_i & en_i;
  assign fault[F_MIS]   = svc & (svc_data_i != match_i);
  assign fault[F_EARLY] = svc & ~fault[F_MIS] & (cnt_q > window_i);
  assign good           = svc & ~fault[F_MIS] & ~fault[F_EARLY];
  assign adv            = tick_i & en_i & ~good & ~start_i & (cnt_q != '0);
  assign fault[F_LATE]  = adv & (cnt_q == WD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sticky_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (start_i || good || fault[F_LATE]) cnt_q <= reload_i;
      else if (adv)                         cnt_q <= cnt_q - 1'b1;
      sticky_q <= sticky_q | fault;
      err_q    <= |fault;
    end
  end

  assign cnt_o    = cnt_q;
  assign sticky_o = sticky_q;
  assign err_o    = err_q;

  a_r9_service_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good |=> (cnt_q == $past(reload_i)));
  a_r6_late_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault[F_LATE] |=> (cnt_q == $past(reload_i)));
  a_r7_early_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault[F_EARLY] && !tick_i) |=> $stable(cnt_q));
  a_r8_mismatch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault[F_MIS] |=> sticky_q[F_MIS]);
  a_r10_err_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (sticky_q != '0));
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import tw_pkg::*;
#(
  parameter int unsigned PRE_W = 5,
  parameter int unsigned TMR_W = 16,
  parameter int unsigned WD_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic              freeze_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              tmr_irq_o,
  output logic              wd_err_o
);
  localparam int unsigned HI = DATA_W / 2;

  logic [PRE_W-1:0]  pre_div;
  logic [TMR_W-1:0]  tload, tcnt;
  logic [2:0]        tctrl;
  logic [WD_W-1:0]   wreload, wwin, wmatch, wcnt;
  logic              wen, tick, tflag, wr;
  logic [1:0]        lock;
  logic [NFAULT-1:0] sticky;

  assign wr = psel_i & penable_i & pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_div <= '0; tload <= '0; tctrl <= '0;
      wreload <= '0; wwin <= '0; wen <= 1'b0; wmatch <= '0;
      lock    <= '0;
    end else if (wr) begin
      case (paddr_i)
        A_PRE:   if (!lock[0]) pre_div <= pwdata_i[PRE_W-1:0];
        A_TLOAD: if (!lock[0]) tload   <= pwdata_i[TMR_W-1:0];
        A_TCTRL: if (!lock[0]) tctrl   <= pwdata_i[2:0];
        A_WCFG:  if (!lock[1]) begin
          wreload <= pwdata_i[WD_W-1:0];
          wwin    <= pwdata_i[HI +: WD_W];
        end
        A_WCTRL: if (!lock[1]) begin
          wen    <= pwdata_i[0];
          wmatch <= pwdata_i[HI +: WD_W];
        end
        A_LOCK:  lock <= lock | pwdata_i[1:0];
        default: ;
      endcase
    end
  end

  tw_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .slow_en_i, .freeze_i,
    .div_i(pre_div), .tick_o(tick)
  );

  tw_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni,
    .tick_i (tick),
    .run_i  (tctrl[TC_RUN]),
    .auto_i (tctrl[TC_AUTO]),
    .load_i (tload),
    .start_i(wr && paddr_i == A_TCTRL && !lock[0] && pwdata_i[0]),
    .clr_i  (wr && paddr_i == A_STAT && pwdata_i[0]),
    .cnt_o  (tcnt),
    .flag_o (tflag)
  );

  tw_watchdog #(.WD_W(WD_W)) u_wd (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .en_i      (wen),
    .start_i   (wr && paddr_i == A_WCTRL && !lock[1] && pwdata_i[0]),
    .reload_i  (wreload),
    .window_i  (wwin),
    .match_i   (wmatch),
    .svc_i     (wr && paddr_i == A_SVC),
    .svc_data_i(pwdata_i[WD_W-1:0]),
    .cnt_o     (wcnt),
    .sticky_o  (sticky),
    .err_o     (wd_err_o)
  );

  assign tmr_irq_o = tflag & tctrl[TC_IE];

  always_comb begin
    prdata_o = '0;
    case (paddr_i)
      A_PRE:   prdata_o[PRE_W-1:0]   = pre_div;
      A_TLOAD: prdata_o[TMR_W-1:0]   = tload;
      A_TCTRL: prdata_o[2:0]         = tctrl;
      A_WCFG:  begin
        prdata_o[WD_W-1:0]  = wreload;
        prdata_o[HI +: WD_W] = wwin;
      end
      A_WCTRL: begin
        prdata_o[0]          = wen;
        prdata_o[HI +: WD_W] = wmatch;
      end
      A_STAT:  prdata_o[NFAULT:0]    = {sticky, tflag};
      A_LOCK:  prdata_o[1:0]         = lock;
      A_TCNT:  prdata_o[TMR_W-1:0]   = tcnt;
      A_WCNT:  prdata_o[WD_W-1:0]    = wcnt;
      default: ;
    endcase
  end

  a_r11_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock[0] |=> lock[0]) );
  a_r11_locked_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock[0] && wr && paddr_i == A_TLOAD) |=> $stable(tload));
  a_r11_locked_wcfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock[1] && wr && paddr_i == A_WCFG) |=> $stable(wreload));
endmodule

// File: tb/tick_watchdog_test.sv
module tick_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b0, freeze = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [15:0] pwdata = '0;
  logic [15:0] prdata;
  logic        irq, err;

  int vectors = 0, fails = 0;
  int slow_per = 1, scnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tick_watchdog uut (
    .clk_i(clk), .rst_ni(rst_n), .slow_en_i(slow_en), .freeze_i(freeze),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite), .paddr_i(paddr),
    .pwdata_i(pwdata), .prdata_o(prdata), .tmr_irq_o(irq), .wd_err_o(err)
  );

  // behavioural reference
  logic [4:0]  m_div, m_pc;
  logic [15:0] m_tload, m_tc;
  logic        m_trun, m_tauto, m_tie, m_flag;
  logic [7:0]  m_wrel, m_wwin, m_wmatch, m_wc;
  logic        m_wen, m_err;
  logic [2:0]  m_st;
  logic [1:0]  m_lock;

  always @(posedge clk) begin : model
    logic w, tk, hit, svc, bad, early, good, late;
    if (!rst_n) begin
      m_div = 0; m_pc = 0; m_tload = 0; m_tc = 0; m_trun = 0; m_tauto = 0; m_tie = 0;
      m_flag = 0; m_wrel = 0; m_wwin = 0; m_wmatch = 0; m_wc = 0; m_wen = 0;
      m_err = 0; m_st = 0; m_lock = 0;
    end else begin
      w  = psel && penable && pwrite;
      tk = 0;
      if (slow_en && !freeze) begin
        if (m_pc == m_div) begin tk = 1; m_pc = 0; end
        else m_pc = m_pc + 1;
      end
      hit = 0;
      if (w && paddr == 2 && !m_lock[0] && pwdata[0]) m_tc = m_tload;
      else if (tk && m_trun && m_tc != 0) begin
        if (m_tc == 1) begin hit = 1; m_tc = m_tauto ? m_tload : 16'd0; end
        else m_tc = m_tc - 1;
      end
      if (hit) m_flag = 1;
      else if (w && paddr == 6 && pwdata[0]) m_flag = 0;
      svc   = w && paddr == 5 && m_wen;
      bad   = svc && pwdata[7:0] != m_wmatch;
      early = svc && !bad && m_wc > m_wwin;
      good  = svc && !bad && !early;
      late  = 0;
      if (w && paddr == 4 && !m_lock[1] && pwdata[0]) m_wc = m_wrel;
      else if (good) m_wc = m_wrel;
      else if (tk && m_wen && m_wc != 0) begin
        if (m_wc == 1) begin late = 1; m_wc = m_wrel; end
        else m_wc = m_wc - 1;
      end
      m_st  = m_st | {bad, late, early};
      m_err = bad | late | early;
      if (w) begin
        case (paddr)
          0: if (!m_lock[0]) m_div = pwdata[4:0];
          1: if (!m_lock[0]) m_tload = pwdata;
          2: if (!m_lock[0]) begin m_trun = pwdata[0]; m_tauto = pwdata[1]; m_tie = pwdata[2]; end
          3: if (!m_lock[1]) begin m_wrel = pwdata[7:0]; m_wwin = pwdata[15:8]; end
          4: if (!m_lock[1]) begin m_wen = pwdata[0]; m_wmatch = pwdata[15:8]; end
          7: m_lock = m_lock | pwdata[1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] m_read(input logic [3:0] a);
    case (a)
      0: return {11'd0, m_div};
      1: return m_tload;
      2: return {13'd0, m_tie, m_tauto, m_trun};
      3: return {m_wwin, m_wrel};
      4: return {m_wmatch, 7'd0, m_wen};
      6: return {12'd0, m_st, m_flag};
      7: return {14'd0, m_lock};
      8: return m_tc;
      9: return {8'd0, m_wc};
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled on the falling edge
  always @(negedge clk) begin
    scnt++;
    if (rst_n && !done) begin
      chk("R3 irq", {15'd0, irq}, {15'd0, m_flag & m_tie});
      chk("R10 err", {15'd0, err}, {15'd0, m_err});
      if (psel && penable && !pwrite) chk("R12 read", prdata, m_read(paddr));
    end
    slow_en <= (scnt % slow_per) == 0;
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; vectors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    logic [15:0] d, d2;
    int n;
    idle(3); rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 10; a++) begin rd(a[3:0], d); chk("R1 reset read", d, 16'd0); end
    chk("R1 irq", {15'd0, irq}, 16'd0);
    // R3/R4 auto-reload periodic timer
    wr(0, 0); wr(1, 5); wr(2, 16'h7);
    n = 0; while (!irq && n < 40) begin idle(1); n++; end
    chk("R3 irq raised", {15'd0, irq}, 16'd1);
    rd(6, d); chk("R3 flag", d & 16'h1, 16'h1);
    wr(6, 1); rd(6, d); chk("R5 flag cleared", d & 16'h1, 16'h0);
    n = 0; while (!irq && n < 40) begin idle(1); n++; end
    chk("R4 auto-reload fires again", {15'd0, irq}, 16'd1);
    wr(6, 1);
    // R4 one-shot holds zero
    wr(1, 3); wr(2, 16'h5); idle(12);
    rd(8, d); chk("R4 one-shot at zero", d, 16'd0);
    idle(10); rd(8, d); chk("R4 stays zero", d, 16'd0);
    // R2 prescaler with a sparser slow pulse
    slow_per = 2; wr(0, 3); wr(1, 1000); wr(2, 16'h3); idle(80);
    rd(8, d); chk("R2 divided count", (d < 16'd1000 && d > 16'd985) ? 16'd1 : 16'd0, 16'd1);
    // R12 freeze
    freeze = 1; rd(8, d); idle(30); rd(8, d2); chk("R12 timer frozen", d2, d);
    freeze = 0; slow_per = 1; idle(20);
    rd(8, d2); chk("R12 timer resumes", (d2 < d) ? 16'd1 : 16'd0, 16'd1);
    wr(2, 0);
    // watchdog: reload 20, window 8, match 5A, tick every 4 clocks
    wr(3, {8'd8, 8'd20}); wr(4, {8'h5A, 8'h01});
    wr(5, 16'h005A); rd(6, d); chk("R7 early fault", d & 16'h2, 16'h2);
    rd(9, d); chk("R7 no reload", (d < 16'd20) ? 16'd1 : 16'd0, 16'd1);
    n = 0; d = 16'd99;
    while (d > 16'd6 && n < 200) begin rd(9, d); n++; end
    wr(5, 16'h005A); rd(9, d); chk("R9 valid reload", (d >= 16'd19) ? 16'd1 : 16'd0, 16'd1);
    rd(6, d); chk("R9 no late yet", d & 16'h4, 16'h0);
    wr(5, 16'h0033); rd(6, d); chk("R8 mismatch fault", d & 16'h8, 16'h8);
    rd(9, d); chk("R8 no reload", (d < 16'd19) ? 16'd1 : 16'd0, 16'd1);
    idle(100); rd(6, d); chk("R6 late fault", d & 16'h4, 16'h4);
    chk("R10 sticky kept", d & 16'hE, 16'hE);
    // R11 locks
    wr(7, 16'h3); wr(1, 16'h1234); rd(1, d); chk("R11 timer locked", d, 16'd1000);
    wr(3, 16'hFFFF); rd(3, d); chk("R11 watchdog locked", d, {8'd8, 8'd20});
    wr(7, 16'h0); rd(7, d); chk("R11 lock kept", d, 16'h3);
    idle(2); rst_n = 0; idle(2); rst_n = 1;
    rd(7, d); chk("R11 reset unlocks", d, 16'h0);
    rd(6, d); chk("R1 status after reset", d, 16'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule